// File: doc/BRIEF.md
# ECC Single-Bit Error Counter and Status Flags

This block sits behind an ECC decoder in a memory controller and turns the decoder's one-cycle event pulses into a small set of health indicators. Each corrected single-bit event advances an 8-bit count. When the advanced count reaches a programmable 8-bit limit, the count returns to zero and a sticky single-bit flag is raised. Each detected multi-bit event raises its own sticky flag. A third sticky flag records a repeat: the limit is reached again while the single-bit flag is still up, or a multi-bit event arrives while the multi-bit flag is still up.

Software loads the limit and the count through simple write strobes. Writing the count to zero is the usual way to restart it. Software clears the flags one at a time by writing 1 to the matching bit of a clear mask, or clears all three with one strobe. All state sits in registers that drive the outputs directly.

Top module: `ecc_err_monitor`

## Requirements
- R1: Synchronous reset sets the count to 0, the limit to THR_RESET (255 by default) and all three flags to 0.
- R2: A single-bit event without a count write in the same cycle adds one to the count on the next clock edge. The single-bit flag is not raised while the advanced count stays below the effective limit. For example, 16 events against a limit of 255 give a count of 16 and no flag.
- R3: When the advanced count is equal to or above the effective limit, the count becomes 0 and the single-bit flag (bit 0 of the flag vector) is set on the same edge.
- R4: A limit hit while the single-bit flag is already set also sets the repeat flag (bit 2).
- R5: A multi-bit event sets the multi-bit flag (bit 1). A first multi-bit event does not set the repeat flag. A multi-bit event while bit 1 is already set also sets bit 2.
- R6: A limit write loads the limit, which appears on `thr_q` on the next cycle. A stored limit of 0 acts as 1, so every single-bit event is a hit.
- R7: A count write loads `cnt_wr_data` into the count. When it falls in the same cycle as a single-bit event, the write wins and the event is dropped.
- R8: `flag_clr` is write-1-to-clear with bit 0 for the single-bit flag, bit 1 for the multi-bit flag and bit 2 for the repeat flag. `clr_all` clears all three. A flag that an event sets in the same cycle stays set. The repeat decision uses the flag values held before that cycle.
- R9: A set flag stays set until a clear names it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sbe_evt | input | 1 | Corrected single-bit event pulse |
| mbe_evt | input | 1 | Detected multi-bit event pulse |
| thr_wr_en | input | 1 | Limit write strobe |
| thr_wr_data | input | CW | Limit write value |
| cnt_wr_en | input | 1 | Count write strobe |
| cnt_wr_data | input | CW | Count write value |
| flag_clr | input | 3 | Per-flag write-1-to-clear mask |
| clr_all | input | 1 | Clear all flags |
| cnt_q | output | CW | Current count |
| thr_q | output | CW | Stored limit |
| flag_sbe | output | 1 | Sticky single-bit flag |
| flag_mbe | output | 1 | Sticky multi-bit flag |
| flag_multi | output | 1 | Sticky repeat flag |

## Verification
With a small limit of 3, runs of single-bit events tell a plain increment apart from a wrap. A second wrap tells a first hit apart from a repeat. Pairs of multi-bit events separate the first event from a repeated one. Cycles where a clear and an event coincide, or a count write and an event coincide, show which side wins. A limit of 0 and a count preloaded above the limit show that the comparison is "at or above" and that 0 acts as 1. Long runs at the reset limit of 255 confirm that the flag stays clear at 16 and at 254 events and rises on the 255th.

// File: rtl/ecc_cnt_pkg.sv
package ecc_cnt_pkg;
  localparam int NFLAG     = 3;
  localparam int FLG_SBE   = 0;
  localparam int FLG_MBE   = 1;
  localparam int FLG_MULTI = 2;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/ecc_sbe_counter.sv
module ecc_sbe_counter #(
  parameter int CW        = 8,
  parameter int THR_RESET = 255
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          thr_we,
  input  logic [CW-1:0] thr_d,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_d,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] thr_q,
  output logic          hit
);
  localparam logic [CW-1:0] THR_INIT = CW'(THR_RESET);
  localparam logic [CW:0]   ONE_W    = (CW+1)'(1);

  logic [CW:0]   cnt_next_w;
  logic [CW:0]   thr_eff_w;

  // A stored limit of zero is treated as one.
  always_comb begin
    thr_eff_w  = (thr_q == '0) ? ONE_W : {1'b0, thr_q};
    cnt_next_w = {1'b0, cnt_q} + ONE_W;
    hit        = inc && !cnt_we && (cnt_next_w >= thr_eff_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= THR_INIT;
    end else if (thr_we) begin
      thr_q <= thr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end else if (hit) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_next_w[CW-1:0];
    end
  end
endmodule

// File: rtl/ecc_sticky_bit.sv
module ecc_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (set) begin
      q <= 1'b1;
    end else if (clr) begin
      q <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_flag_bank.sv
module ecc_flag_bank
  import ecc_cnt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sbe_hit,
  input  logic      mbe_evt,
  input  flag_vec_t clr_mask,
  input  logic      clr_all,
  output flag_vec_t flags
);
  flag_vec_t set_vec;
  flag_vec_t clr_vec;

  // Repeat decisions use the flag values held before this cycle.
  always_comb begin
    set_vec            = '0;
    set_vec[FLG_SBE]   = sbe_hit;
    set_vec[FLG_MBE]   = mbe_evt;
    set_vec[FLG_MULTI] = (sbe_hit && flags[FLG_SBE]) ||
                         (mbe_evt && flags[FLG_MBE]);
    clr_vec            = clr_mask | {NFLAG{clr_all}};
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    ecc_sticky_bit u_bit (
      .clk (clk),
      .rst (rst),
      .set (set_vec[i]),
      .clr (clr_vec[i]),
      .q   (flags[i])
    );
  end
endmodule

// File: rtl/ecc_err_monitor.sv
module ecc_err_monitor
  import ecc_cnt_pkg::*;
#(
  parameter int CW        = 8,
  parameter int THR_RESET = 255
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sbe_evt,
  input  logic          mbe_evt,
  input  logic          thr_wr_en,
  input  logic [CW-1:0] thr_wr_data,
  input  logic          cnt_wr_en,
  input  logic [CW-1:0] cnt_wr_data,
  input  logic [2:0]    flag_clr,
  input  logic          clr_all,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] thr_q,
  output logic          flag_sbe,
  output logic          flag_mbe,
  output logic          flag_multi
);
  logic      sbe_hit;
  flag_vec_t flags;

  ecc_sbe_counter #(.CW(CW), .THR_RESET(THR_RESET)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .inc    (sbe_evt),
    .thr_we (thr_wr_en),
    .thr_d  (thr_wr_data),
    .cnt_we (cnt_wr_en),
    .cnt_d  (cnt_wr_data),
    .cnt_q  (cnt_q),
    .thr_q  (thr_q),
    .hit    (sbe_hit)
  );

  ecc_flag_bank u_flags (
    .clk      (clk),
    .rst      (rst),
    .sbe_hit  (sbe_hit),
    .mbe_evt  (mbe_evt),
    .clr_mask (flag_clr),
    .clr_all  (clr_all),
    .flags    (flags)
  );

  assign flag_sbe   = flags[FLG_SBE];
  assign flag_mbe   = flags[FLG_MBE];
  assign flag_multi = flags[FLG_MULTI];
endmodule

// File: rtl/ecc_err_monitor_chk.sv
module ecc_err_monitor_chk #(
  parameter int CW        = 8,
  parameter int THR_RESET = 255
) (
  input logic          clk,
  input logic          rst,
  input logic          sbe_evt,
  input logic          mbe_evt,
  input logic          thr_wr_en,
  input logic [CW-1:0] thr_wr_data,
  input logic          cnt_wr_en,
  input logic [CW-1:0] cnt_wr_data,
  input logic [2:0]    flag_clr,
  input logic          clr_all,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] thr_q,
  input logic          flag_sbe,
  input logic          flag_mbe,
  input logic          flag_multi
);
  logic [2:0] flg_now;
  logic [2:0] flg_kept;
  assign flg_now  = {flag_multi, flag_mbe, flag_sbe};
  assign flg_kept = flg_now & ~(flag_clr | {3{clr_all}});

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (cnt_q == '0) && (flg_now == 3'b000) && (thr_q == CW'(THR_RESET)));

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    sbe_evt && !cnt_wr_en |=> (cnt_q == $past(cnt_q) + 1'b1) || ((cnt_q == '0) && flag_sbe));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
    !sbe_evt && !cnt_wr_en |=> $stable(cnt_q));

  a_r4_repeat_hit: assert property (@(posedge clk) disable iff (rst)
    flag_sbe && sbe_evt && !cnt_wr_en |=> (cnt_q != '0) || flag_multi);

  a_r5_mbe_set: assert property (@(posedge clk) disable iff (rst)
    mbe_evt |=> flag_mbe);

  a_r5_mbe_repeat: assert property (@(posedge clk) disable iff (rst)
    mbe_evt && flag_mbe |=> flag_multi);

  a_r6_thr_load: assert property (@(posedge clk) disable iff (rst)
    thr_wr_en |=> thr_q == $past(thr_wr_data));

  a_r7_cnt_load: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_en |=> cnt_q == $past(cnt_wr_data));

  a_r8_clear_all: assert property (@(posedge clk) disable iff (rst)
    clr_all && !sbe_evt && !mbe_evt |=> (flg_now == 3'b000));

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flg_now & $past(flg_kept)) == $past(flg_kept)));
endmodule

bind ecc_err_monitor ecc_err_monitor_chk #(.CW(CW), .THR_RESET(THR_RESET)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sbe_evt     (sbe_evt),
  .mbe_evt     (mbe_evt),
  .thr_wr_en   (thr_wr_en),
  .thr_wr_data (thr_wr_data),
  .cnt_wr_en   (cnt_wr_en),
  .cnt_wr_data (cnt_wr_data),
  .flag_clr    (flag_clr),
  .clr_all     (clr_all),
  .cnt_q       (cnt_q),
  .thr_q       (thr_q),
  .flag_sbe    (flag_sbe),
  .flag_mbe    (flag_mbe),
  .flag_multi  (flag_multi)
);

// File: tb/tb_ecc_err_monitor.sv
module tb_ecc_err_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 20;
  localparam int WDOG_LIMIT = 20000;

  // {sbe, mbe, thr_we, thr_d[8], cnt_we, cnt_d[8], clr[3], clr_all, exp_cnt[8], exp_flags[3]}
  // exp_flags = {repeat, multi-bit, single-bit}
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b0,1'b0,1'b1,8'd3,1'b0,8'd0,3'b000,1'b0, 8'd0,3'b000}, // R6 limit 3
    {1'b1,1'b0,1'b0,8'd0,1'b0,8'd0,3'b000,1'b0, 8'd1,3'b000}, // R2
    {1'b1,1'b0,1'b0,8'd0,1'b0,8'd0,3'b000,1'b0, 8'd2,3'b000}, // R2
    {1'b1,1'b0,1'b0,8'd0,1'b0,8'd0,3'b000,1'b0, 8'd0,3'b001}, // R3 wrap
    {1'b1,1'b0,1'b0,8'd0,1'b0,8'd0,3'b000,1'b0, 8'd1,3'b001}, // R9
    {1'b1,1'b0,1'b0,8'd0,1'b0,8'd0,3'b000,1'b0, 8'd2,3'b001},
    {1'b1,1'b0,1'b0,8'd0,1'b0,8'd0,3'b000,1'b0, 8'd0,3'b101}, // R4 repeat
    {1'b0,1'b1,1'b0,8'd0,1'b0,8'd0,3'b000,1'b0, 8'd0,3'b111}, // R5
    {1'b0,1'b0,1'b0,8'd0,1'b0,8'd0,3'b000,1'b1, 8'd0,3'b000}, // R8 clear all
    {1'b0,1'b1,1'b0,8'd0,1'b0,8'd0,3'b000,1'b0, 8'd0,3'b010}, // R5 first alone
    {1'b0,1'b1,1'b0,8'd0,1'b0,8'd0,3'b010,1'b0, 8'd0,3'b110}, // R8 event wins, R5 repeat
    {1'b0,1'b0,1'b0,8'd0,1'b0,8'd0,3'b100,1'b0, 8'd0,3'b010}, // R8 single clear
    {1'b0,1'b0,1'b0,8'd0,1'b1,8'd5,3'b000,1'b0, 8'd5,3'b010}, // R7 load
    {1'b1,1'b0,1'b0,8'd0,1'b0,8'd0,3'b000,1'b0, 8'd0,3'b011}, // R3 above limit
    {1'b1,1'b0,1'b0,8'd0,1'b1,8'd2,3'b000,1'b0, 8'd2,3'b011}, // R7 write wins
    {1'b0,1'b0,1'b1,8'd0,1'b0,8'd0,3'b000,1'b0, 8'd2,3'b011}, // R6 limit 0
    {1'b1,1'b0,1'b0,8'd0,1'b0,8'd0,3'b000,1'b0, 8'd0,3'b111}, // R6 zero acts as one, R4
    {1'b0,1'b0,1'b0,8'd0,1'b0,8'd0,3'b000,1'b1, 8'd0,3'b000}, // R8
    {1'b1,1'b0,1'b0,8'd0,1'b0,8'd0,3'b000,1'b0, 8'd0,3'b001}, // R6 single event hit
    {1'b1,1'b0,1'b0,8'd0,1'b0,8'd0,3'b001,1'b0, 8'd0,3'b101}  // R8 set beats clear, R4
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sbe_evt = 1'b0, mbe_evt = 1'b0;
  logic       thr_wr_en = 1'b0, cnt_wr_en = 1'b0;
  logic [7:0] thr_wr_data = '0, cnt_wr_data = '0;
  logic [2:0] flag_clr = '0;
  logic       clr_all = 1'b0;
  logic [7:0] cnt_q, thr_q;
  logic       flag_sbe, flag_mbe, flag_multi;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_monitor dut (
    .clk(clk), .rst(rst), .sbe_evt(sbe_evt), .mbe_evt(mbe_evt),
    .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .flag_clr(flag_clr), .clr_all(clr_all),
    .cnt_q(cnt_q), .thr_q(thr_q),
    .flag_sbe(flag_sbe), .flag_mbe(flag_mbe), .flag_multi(flag_multi)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Inputs change at a falling edge; results are sampled at the next falling edge.
  task automatic cycle(input logic [34:0] v);
    sbe_evt     = v[34];
    mbe_evt     = v[33];
    thr_wr_en   = v[32];
    thr_wr_data = v[31:24];
    cnt_wr_en   = v[23];
    cnt_wr_data = v[22:15];
    flag_clr    = v[14:12];
    clr_all     = v[11];
    @(negedge clk);
    sbe_evt = 1'b0; mbe_evt = 1'b0; thr_wr_en = 1'b0; cnt_wr_en = 1'b0;
    flag_clr = '0; clr_all = 1'b0;
  endtask

  task automatic pulse_sbe(input int n);
    for (int k = 0; k < n; k++) cycle({1'b1, 34'd0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 count after reset", cnt_q, 0);
    check("R1 limit after reset", thr_q, 255);
    check("R1 flags after reset", {flag_multi, flag_mbe, flag_sbe}, 0);

    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i]);
      check($sformatf("R2-vector %0d count", i), cnt_q, VEC[i][10:3]);
      check($sformatf("R8-vector %0d flags", i), {flag_multi, flag_mbe, flag_sbe}, VEC[i][2:0]);
    end
    check("R6 limit readback", thr_q, 0);

    // R1: reset from a busy state
    cycle({1'b0,1'b0,1'b0,8'd0,1'b1,8'd77,3'b000,1'b0,11'd0});
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 count cleared", cnt_q, 0);
    check("R1 limit restored", thr_q, 255);
    check("R1 flags cleared", {flag_multi, flag_mbe, flag_sbe}, 0);

    // R2: 16 events against the default limit
    pulse_sbe(16);
    check("R2 count at 16", cnt_q, 16);
    check("R2 flag clear below limit", flag_sbe, 0);
    pulse_sbe(238);
    check("R2 count at 254", cnt_q, 254);
    check("R2 flag clear at 254", flag_sbe, 0);
    pulse_sbe(1);
    check("R3 wrap at 255", cnt_q, 0);
    check("R3 flag at 255", flag_sbe, 1);
    check("R4 no repeat on first hit", flag_multi, 0);

    // R9: flags hold over idle cycles
    repeat (5) @(negedge clk);
    check("R9 flag still set", flag_sbe, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < WDOG_LIMIT; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule